// File: doc/BRIEF.md
# Serial ADC Readout Host

This block is the host-side master for a 12-bit converter whose result is shifted out serially under a clock the host supplies. It owns three control lines toward the converter: an active-low select, a read/convert line and the bit clock. It takes in the converter's busy flag and serial data line. A start request begins a conversion with a short low pulse on read/convert while select is low. Read/convert then returns high, which puts the converter in output mode, and the result is shifted in most significant bit first. The host delivers each assembled 12-bit word with a one-cycle strobe.

Reading normally overlaps the next conversion. At the start of conversion n+1, any result of conversion n that has not yet been read is clocked out. Partway through every conversion the converter loads its new result into its output register. That load happens somewhere between a fixed delay after the start and the rise of busy. A bit clock that is high at that moment, while read/convert is high, destroys the result. The host therefore times each conversion with a counter and never lets the bit clock be high inside that window. If a readout cannot finish its next high phase before the window opens, the partial word is dropped. The host then waits for busy and reads the newer result from its first bit.

Top module: `adc_serial_host`

## Requirements
- R1: While reset is held and after it is released, select is high, read/convert is high, the bit clock is low and the word strobe is low.
- R2: A start request seen while idle drives select low and read/convert low together for exactly CONV_CYC cycles. Read/convert then goes high while select stays low until the controller returns to idle.
- R3: The bit clock is high only while select is low and read/convert is high. Its first rise in any conversion comes at least SETUP_CYC cycles after read/convert goes high.
- R4: Each bit clock high phase lasts HI_CYC cycles. Consecutive bits of a word are separated by LO_CYC low cycles. A word takes exactly 12 high phases.
- R5: The serial input is sampled in the last cycle of each high phase. The first bit sampled lands in word bit 11 and the last in bit 0. The strobe is high for one cycle, the cycle after the twelfth sample.
- R6: When a start is accepted and an earlier result is still unread, that result is clocked out during the new conversion, before busy rises.
- R7: From WIN_CYC cycles after the conversion pulse begins until busy has risen, the bit clock stays low.
- R8: If the next high phase of an overlapped readout would not end before the window of R7, the partial word is discarded with no strobe. After busy rises, the new result is read from its first bit and delivered.
- R9: A conversion that starts with no unread result causes no clocking during that conversion. Its result is read at the next start. A result delivered through R8 counts as read.
- R10: A start request is ignored until busy has risen for the current conversion and any readout has finished. Such a request causes no conversion pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to begin a conversion; taken only when idle |
| busy_i | input | 1 | Converter busy flag, low during a conversion (asynchronous) |
| sdata_i | input | 1 | Serial result bit from the converter |
| cs_n_o | output | 1 | Active-low converter select |
| rc_o | output | 1 | Read/convert: low pulse starts a conversion, high enables output |
| dclk_o | output | 1 | Bit clock to the converter |
| word_o | output | 12 | Last assembled result word |
| word_vld_o | output | 1 | One-cycle strobe marking a new word_o |

## Verification
The bench pairs the host with a behavioural converter that loads each result at the end of a conversion and flags any bit clock high inside the load window. A host that mistimed the window or clocked outside output mode would raise that flag. A host that shifted the wrong edge, or in the wrong order, would return a word that differs from the loaded value. The first conversion must produce no word, and an overlapped word must appear while busy is still low. A host that reused stale data or read twice would show an extra or misplaced strobe. A second instance with a short window forces the abort path: a host that delivered the partial word, or failed to restart at the first bit after busy, would give a wrong word or the wrong number of strobes. Start requests held through a conversion check that no extra conversion pulse is issued.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_WAITB
  } host_st_t;

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync (
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  output logic busy_rise
);
  logic [2:0] sq;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq        <= 3'b111;
      busy_rise <= 1'b0;
    end else begin
      sq        <= {sq[1:0], busy_i};
      busy_rise <= sq[1] & ~sq[2];
    end
  end
endmodule

// File: rtl/adc_win_timer.sv
module adc_win_timer #(
  parameter int WIN_CYC = 2400,
  parameter int HI_CYC  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic room_ok,
  output logic win_open
);
  localparam int CW = $clog2(WIN_CYC + HI_CYC + 2);
  localparam logic [CW-1:0] WIN_V  = CW'(WIN_CYC);
  localparam logic [CW-1:0] NEED_V = CW'(HI_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= WIN_V;
    end else if (restart) begin
      cnt <= '0;
    end else if (cnt < WIN_V) begin
      cnt <= cnt + 1'b1;
    end
  end

  // a high phase decided now ends strictly before the window opens
  assign room_ok  = (cnt + NEED_V) <= WIN_V;
  assign win_open = (cnt >= WIN_V);
endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample,
  input  logic          last,
  input  logic          sdata,
  output logic [DW-1:0] word,
  output logic          vld
);
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      word <= '0;
      vld  <= 1'b0;
    end else begin
      vld <= 1'b0;
      if (sample) begin
        sh <= {sh[DW-2:0], sdata};
        if (last) begin
          word <= {sh[DW-2:0], sdata};
          vld  <= 1'b1;
        end
      end
    end
  end

  p_vld_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    vld |=> !vld);
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host #(
  parameter int DATA_W    = 12,
  parameter int CONV_CYC  = 8,
  parameter int SETUP_CYC = 6,
  parameter int HI_CYC    = 10,
  parameter int LO_CYC    = 10,
  parameter int WIN_CYC   = 2400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              busy_i,
  input  logic              sdata_i,
  output logic              cs_n_o,
  output logic              rc_o,
  output logic              dclk_o,
  output logic [DATA_W-1:0] word_o,
  output logic              word_vld_o
);
  import adc_host_pkg::*;

  localparam int MAXC = (CONV_CYC > SETUP_CYC ? CONV_CYC : SETUP_CYC) >
                        (HI_CYC > LO_CYC ? HI_CYC : LO_CYC) ?
                        (CONV_CYC > SETUP_CYC ? CONV_CYC : SETUP_CYC) :
                        (HI_CYC > LO_CYC ? HI_CYC : LO_CYC);
  localparam int PW = $clog2(MAXC + 1);
  localparam int BW = $clog2(DATA_W);
  localparam logic [PW-1:0] PC_CONV  = PW'(CONV_CYC - 1);
  localparam logic [PW-1:0] PC_SETUP = PW'(SETUP_CYC - 1);
  localparam logic [PW-1:0] PC_HI    = PW'(HI_CYC - 1);
  localparam logic [PW-1:0] PC_LO    = PW'(LO_CYC - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

  host_st_t      st, st_n;
  logic [PW-1:0] pcnt, pcnt_n;
  logic [BW-1:0] bit_idx, bit_n;
  logic          have_prev, have_n;
  logic          pend, pend_n;
  logic          post, post_n;
  logic          busy_done;
  logic          busy_rise, room_ok, win_open;
  logic          restart, sample, last;

  adc_busy_sync u_sync (
    .clk       (clk),
    .rst       (rst),
    .busy_i    (busy_i),
    .busy_rise (busy_rise)
  );

  adc_win_timer #(.WIN_CYC(WIN_CYC), .HI_CYC(HI_CYC)) u_win (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .room_ok  (room_ok),
    .win_open (win_open)
  );

  adc_rx_shift #(.DW(DATA_W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .sample (sample),
    .last   (last),
    .sdata  (sdata_i),
    .word   (word_o),
    .vld    (word_vld_o)
  );

  always_comb begin
    st_n    = st;
    pcnt_n  = pcnt + 1'b1;
    bit_n   = bit_idx;
    have_n  = have_prev;
    pend_n  = pend;
    post_n  = post;
    restart = 1'b0;
    sample  = 1'b0;
    last    = 1'b0;
    unique case (st)
      ST_IDLE: begin
        pcnt_n = '0;
        if (start_req) begin
          st_n    = ST_PULSE;
          restart = 1'b1;
        end
      end
      ST_PULSE: begin
        if (pcnt == PC_CONV) begin
          st_n   = ST_SETUP;
          pcnt_n = '0;
        end
      end
      ST_SETUP: begin
        if (pcnt == PC_SETUP) begin
          pcnt_n = '0;
          bit_n  = '0;
          post_n = 1'b0;
          if (!have_prev) begin
            st_n   = ST_WAITB;
            pend_n = 1'b0;
          end else if (room_ok) begin
            st_n = ST_HIGH;
          end else begin
            st_n   = ST_WAITB;
            pend_n = 1'b1;
          end
        end
      end
      ST_HIGH: begin
        if (pcnt == PC_HI) begin
          sample = 1'b1;
          last   = (bit_idx == BIT_LAST);
          st_n   = ST_LOW;
          pcnt_n = '0;
        end
      end
      ST_LOW: begin
        if (pcnt == PC_LO) begin
          pcnt_n = '0;
          if (bit_idx == BIT_LAST) begin
            if (post) begin
              st_n   = ST_IDLE;
              have_n = 1'b0;
            end else begin
              st_n   = ST_WAITB;
              pend_n = 1'b0;
            end
          end else begin
            bit_n = bit_idx + 1'b1;
            if (post || room_ok) begin
              st_n = ST_HIGH;
            end else begin
              st_n   = ST_WAITB;
              pend_n = 1'b1;
            end
          end
        end
      end
      ST_WAITB: begin
        pcnt_n = '0;
        if (busy_done) begin
          if (pend) begin
            st_n   = ST_HIGH;
            post_n = 1'b1;
            bit_n  = '0;
          end else begin
            st_n   = ST_IDLE;
            have_n = 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pcnt      <= '0;
      bit_idx   <= '0;
      have_prev <= 1'b0;
      pend      <= 1'b0;
      post      <= 1'b0;
      busy_done <= 1'b0;
      cs_n_o    <= 1'b1;
      rc_o      <= 1'b1;
      dclk_o    <= 1'b0;
    end else begin
      st        <= st_n;
      pcnt      <= pcnt_n;
      bit_idx   <= bit_n;
      have_prev <= have_n;
      pend      <= pend_n;
      post      <= post_n;
      if (restart)        busy_done <= 1'b0;
      else if (busy_rise) busy_done <= 1'b1;
      cs_n_o    <= (st_n == ST_IDLE);
      rc_o      <= (st_n != ST_PULSE);
      dclk_o    <= (st_n == ST_HIGH);
    end
  end

  p_pulse_sel_r2: assert property (@(posedge clk) disable iff (rst)
    !rc_o |-> !cs_n_o);

  p_out_mode_r3: assert property (@(posedge clk) disable iff (rst)
    dclk_o |-> (rc_o && !cs_n_o));

  // holds for SETUP_CYC of 4 or more
  p_setup_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(dclk_o) |-> ($past(rc_o, 1) && $past(rc_o, 4)));

  p_window_r7: assert property (@(posedge clk) disable iff (rst)
    (win_open && !busy_done && !cs_n_o) |-> !dclk_o);
endmodule

// File: tb/adc_conv_model.sv
module adc_conv_model #(
  parameter int CONV_T = 400,
  parameter int WIN_T  = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rc,
  input  logic dclk,
  output logic busy,
  output logic sdata,
  output logic viol,
  output int   nconv
);
  logic        prev_rc, prev_dclk, active;
  logic [11:0] outreg;
  int          cnt, ptr;

  function automatic logic [11:0] res_of(input int k);
    case (k)
      0: return 12'h000;
      1: return 12'hFFF;
      2: return 12'h800;
      3: return 12'h001;
      default: return 12'(k * 12'h3A7) ^ 12'h5C3;
    endcase
  endfunction

  assign sdata = (ptr < 12) ? outreg[11 - ptr] : 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1; active <= 1'b0; ptr <= 12; outreg <= '0;
      viol <= 1'b0; nconv <= 0; prev_rc <= 1'b1; prev_dclk <= 1'b0; cnt <= 0;
    end else begin
      prev_rc   <= rc;
      prev_dclk <= dclk;
      if (!cs_n && rc && prev_dclk && !dclk && ptr < 12) ptr <= ptr + 1;
      if (!cs_n && prev_rc && !rc && !active) begin
        active <= 1'b1; cnt <= 0; busy <= 1'b0;
      end else if (active) begin
        cnt <= cnt + 1;
        if (cnt >= WIN_T && !cs_n && rc && dclk) viol <= 1'b1;
        if (cnt == CONV_T - 1) begin
          active <= 1'b0; busy <= 1'b1;
          outreg <= res_of(nconv); ptr <= 0; nconv <= nconv + 1;
        end
      end
    end
  end
endmodule

// File: tb/sim_adc_serial_host.sv
module sim_adc_serial_host;
  localparam int CONV_CYC = 8, SETUP_CYC = 6, HI_CYC = 10, LO_CYC = 10;
  localparam int WIN0 = 300, CT0 = 400, WIN1 = 100, CT1 = 200;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] res_of(input int k);
    case (k)
      0: return 12'h000;
      1: return 12'hFFF;
      2: return 12'h800;
      3: return 12'h001;
      default: return 12'(k * 12'h3A7) ^ 12'h5C3;
    endcase
  endfunction

  // instance 0: overlapped readout fits before the window
  logic start0 = 1'b0, busy0, sd0, cs0, rc0, dk0, vld0, viol0;
  logic [11:0] word0;
  int nconv0;
  adc_serial_host #(.CONV_CYC(CONV_CYC), .SETUP_CYC(SETUP_CYC), .HI_CYC(HI_CYC),
                    .LO_CYC(LO_CYC), .WIN_CYC(WIN0)) u0 (
    .clk(clk), .rst(rst), .start_req(start0), .busy_i(busy0), .sdata_i(sd0),
    .cs_n_o(cs0), .rc_o(rc0), .dclk_o(dk0), .word_o(word0), .word_vld_o(vld0));
  adc_conv_model #(.CONV_T(CT0), .WIN_T(WIN0)) m0 (
    .clk(clk), .rst(rst), .cs_n(cs0), .rc(rc0), .dclk(dk0),
    .busy(busy0), .sdata(sd0), .viol(viol0), .nconv(nconv0));

  // instance 1: window too short, forces the abort path
  logic start1 = 1'b0, busy1, sd1, cs1, rc1, dk1, vld1, viol1;
  logic [11:0] word1;
  int nconv1;
  adc_serial_host #(.CONV_CYC(CONV_CYC), .SETUP_CYC(SETUP_CYC), .HI_CYC(HI_CYC),
                    .LO_CYC(LO_CYC), .WIN_CYC(WIN1)) u1 (
    .clk(clk), .rst(rst), .start_req(start1), .busy_i(busy1), .sdata_i(sd1),
    .cs_n_o(cs1), .rc_o(rc1), .dclk_o(dk1), .word_o(word1), .word_vld_o(vld1));
  adc_conv_model #(.CONV_T(CT1), .WIN_T(WIN1)) m1 (
    .clk(clk), .rst(rst), .cs_n(cs1), .rc(rc1), .dclk(dk1),
    .busy(busy1), .sdata(sd1), .viol(viol1), .nconv(nconv1));

  // per-clock reference checks on instance 0
  int exp0_q[$];
  int falls0 = 0, vcnt0 = 0, vcnt1 = 0;
  int rc_low = 0, since_rc = 0, hi_run = 0, lo_run = 0, rises = 0;
  logic p_rc = 1'b1, p_dk = 1'b0, p_v0 = 1'b0, p_v1 = 1'b0, have_fall = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!rc0) begin
        if (p_rc) begin
          falls0++;
          chk(!cs0, "R2 select low with pulse", cs0, 0);
        end
        rc_low++; since_rc = 0; have_fall = 1'b0; rises = 0;
      end else begin
        if (!p_rc) chk(rc_low == CONV_CYC, "R2 pulse width", rc_low, CONV_CYC);
        if (!p_rc) chk(!cs0, "R2 select held after pulse", cs0, 0);
        rc_low = 0; since_rc++;
      end
      if (dk0) chk(!cs0 && rc0, "R3 clock only in output mode", {cs0, rc0}, 1);
      if (dk0 && !p_dk) begin
        rises++;
        if (have_fall) chk(lo_run == LO_CYC, "R4 low phase", lo_run, LO_CYC);
        else chk(since_rc >= SETUP_CYC + 1, "R3 setup", since_rc, SETUP_CYC + 1);
        hi_run = 1; lo_run = 0;
      end else if (!dk0 && p_dk) begin
        chk(hi_run == HI_CYC, "R4 high phase", hi_run, HI_CYC);
        lo_run = 1; have_fall = 1'b1;
      end else if (dk0) hi_run++;
      else lo_run++;
      if (p_v0) chk(!vld0, "R5 strobe one cycle", vld0, 0);
      if (vld0) begin
        vcnt0++;
        chk(rises == 12, "R4 twelve high phases", rises, 12);
        chk(!busy0, "R6 word during next conversion", busy0, 0);
        if (exp0_q.size() == 0) chk(0, "R5 unexpected word", word0, 0);
        else begin
          int e;
          e = exp0_q.pop_front();
          chk(word0 == 12'(e), "R5 word MSB first", word0, e);
        end
      end
      if (p_v1) chk(!vld1, "R5 strobe one cycle u1", vld1, 0);
      if (vld1) begin
        vcnt1++;
        chk(word1 == res_of(1), "R8 restarted word", word1, res_of(1));
        chk(busy1, "R8 word after busy", busy1, 1);
      end
      p_rc = rc0; p_dk = dk0; p_v0 = vld0; p_v1 = vld1;
    end
  end

  task automatic conv0(input int n);
    if (n >= 1) exp0_q.push_back(res_of(n - 1));
    @(negedge clk); start0 = 1'b1;
    while (rc0) @(negedge clk);
    start0 = 1'b0;
  endtask

  task automatic conv1;
    @(negedge clk); start1 = 1'b1;
    while (rc1) @(negedge clk);
    start1 = 1'b0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(cs0 && rc0 && !dk0 && !vld0, "R1 reset state", {cs0, rc0, dk0, vld0}, 4'b1100);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(cs0 && rc0 && !dk0 && !vld0, "R1 after release", {cs0, rc0, dk0, vld0}, 4'b1100);

    conv0(0);
    repeat (CT0 + 40) @(negedge clk);
    chk(vcnt0 == 0, "R9 no read on first conversion", vcnt0, 0);
    for (int n = 1; n < 6; n++) begin
      conv0(n);
      if (n == 3) begin
        repeat (300) @(negedge clk);
        start0 = 1'b1;
        repeat (60) @(negedge clk);
        start0 = 1'b0;
        repeat (CT0 - 320) @(negedge clk);
        chk(falls0 == 4, "R10 start ignored while busy", falls0, 4);
      end else begin
        repeat (CT0 + 40) @(negedge clk);
      end
    end
    chk(vcnt0 == 5, "R6 words delivered", vcnt0, 5);
    chk(exp0_q.size() == 0, "R6 all results read", exp0_q.size(), 0);
    chk(!viol0, "R7 no clock in window u0", viol0, 0);
    chk(nconv0 == 6, "R10 conversion count", nconv0, 6);

    conv1;
    repeat (CT1 + 40) @(negedge clk);
    conv1;
    repeat (CT1 + 320) @(negedge clk);
    chk(vcnt1 == 1, "R8 partial dropped, one word", vcnt1, 1);
    conv1;
    repeat (CT1 + 40) @(negedge clk);
    chk(vcnt1 == 1, "R9 no read after restarted word", vcnt1, 1);
    chk(!viol1, "R7 no clock in window u1", viol1, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule